// File: doc/BRIEF.md
# Sequential Shift-Add Binary Multiplier

This block forms the unsigned product of two WIDTH-bit operands using only one WIDTH-bit adder. A start pulse copies both operands into internal registers. A small controller then runs WIDTH iterations. In each iteration it first adds the multiplicand into an accumulator, but only if the current multiplier bit is 1. It then shifts a right-moving chain of carry bit, accumulator and multiplier register by one place, and counts one iteration down.

The product is the accumulator (upper half) joined to the multiplier register (lower half). Every iteration costs two clock cycles, so an operation takes 2*WIDTH cycles after the start is sampled. A ready output tells the caller when the block is idle and the product is valid. The product then stays unchanged until the next accepted start.

Top module: `seq_shift_add_mult`

## Requirements
- R1: After reset, `ready_o` is 1 and `prod_o` is 0.
- R2: A `go_i` pulse seen at a clock edge while `ready_o` is 1 starts an operation, and `ready_o` is 0 after that edge.
- R3: `ready_o` returns to 1 exactly 2*WIDTH clock edges after the edge that accepted the start. `prod_o` then equals the unsigned product of the captured operands, multiplicand times multiplier, 2*WIDTH bits wide.
- R4: While `ready_o` is 1 and `go_i` is 0, `prod_o` keeps its value.
- R5: `go_i` asserted while `ready_o` is 0 is ignored. The result and the completion cycle match those of an operation with no such pulse.
- R6: The operands are captured only at the accepted start edge. Changing `mcand_i` or `mplier_i` during an operation does not change the result.
- R7: Corner operands give correct products. A zero multiplier, where every add is skipped, gives 0. A zero multiplicand gives 0. All-ones times all-ones, where the adder carry-out is taken on most iterations, gives (2^WIDTH-1)^2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start request, acted on only while ready |
| mcand_i | input | WIDTH | Multiplicand operand |
| mplier_i | input | WIDTH | Multiplier operand |
| prod_o | output | 2*WIDTH | Product: accumulator high, multiplier register low |
| ready_o | output | 1 | Idle and product valid |

## Verification
Two functions can fall in the same cycle. The first is a new start request. The second is either an operation in progress or the final shift that ends one. The bench raises `go_i` in the middle of a multiplication and in the cycle just before completion. It then checks that `ready_o` still rises on the expected edge and that the product belongs to the first operand pair. It also changes the operand inputs while the block is busy. A separate case applies a start on the first ready cycle, to confirm that the back-to-back start is accepted and leaves the previous product untouched until that edge.

// File: rtl/mult_pkg.sv
package mult_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ADD   = 2'd1,
      ST_SHIFT = 2'd2
   } mult_state_t;

   localparam int ADDER_BEHAV  = 0;
   localparam int ADDER_RIPPLE = 1;
endpackage

// File: rtl/mult_adder.sv
module mult_adder #(
   parameter int WIDTH = 8,
   parameter int STYLE = 0
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);
   initial begin
      assert (STYLE == mult_pkg::ADDER_BEHAV || STYLE == mult_pkg::ADDER_RIPPLE)
         else $error("mult_adder: unknown STYLE %0d", STYLE);
   end

   generate
      if (STYLE == mult_pkg::ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]  = x_i[i] ^ y_i[i] ^ cy[i];
            assign cy[i+1]   = (x_i[i] & y_i[i]) | (cy[i] & (x_i[i] ^ y_i[i]));
         end
         assign cout_o = cy[WIDTH];
      end else begin : g_behav
         logic [WIDTH:0] full;
         assign full   = {1'b0, x_i} + {1'b0, y_i};
         assign sum_o  = full[WIDTH-1:0];
         assign cout_o = full[WIDTH];
      end
   endgenerate
endmodule

// File: rtl/mult_iter_cnt.sv
module mult_iter_cnt #(
   parameter int WIDTH = 8,
   localparam int CW = $clog2(WIDTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic dec_i,
   output logic last_o
);
   localparam logic [CW-1:0] LOAD_VAL = CW'(WIDTH);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= LOAD_VAL;
      else if (dec_i)  cnt_q <= cnt_q - 1'b1;
   end

   assign last_o = (cnt_q == CW'(1));

   p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD_VAL);
   p_no_dec_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dec_i |-> cnt_q != '0);
endmodule

// File: rtl/mult_ctrl.sv
module mult_ctrl #(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic load_o,
   output logic add_o,
   output logic shift_o,
   output logic ready_o
);
   import mult_pkg::*;

   mult_state_t st_q, st_d;
   logic        last;

   mult_iter_cnt #(.WIDTH(WIDTH)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_o),
      .dec_i  (shift_o),
      .last_o (last)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (go_i) st_d = ST_ADD;
         ST_ADD:   st_d = ST_SHIFT;
         ST_SHIFT: st_d = last ? ST_IDLE : ST_ADD;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign ready_o = (st_q == ST_IDLE);
   assign load_o  = ready_o & go_i;
   assign add_o   = (st_q == ST_ADD);
   assign shift_o = (st_q == ST_SHIFT);

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && go_i) |=> !ready_o);
   p_add_then_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      add_o |=> shift_o);
   p_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_o && last) |=> ready_o);
   p_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_o, add_o, shift_o}));
endmodule

// File: rtl/mult_dpath.sv
module mult_dpath #(
   parameter int WIDTH = 8,
   parameter int ADDER = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic               add_i,
   input  logic               shift_i,
   input  logic [WIDTH-1:0]   mcand_i,
   input  logic [WIDTH-1:0]   mplier_i,
   output logic [2*WIDTH-1:0] prod_o
);
   logic [WIDTH-1:0] b_q, acc_q, mq_q;
   logic             cy_q;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic             do_add;

   mult_adder #(.WIDTH(WIDTH), .STYLE(ADDER)) u_add (
      .x_i    (acc_q),
      .y_i    (b_q),
      .sum_o  (sum),
      .cout_o (cout)
   );

   assign do_add = add_i & mq_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_q   <= '0;
         acc_q <= '0;
         mq_q  <= '0;
         cy_q  <= 1'b0;
      end else if (load_i) begin
         b_q   <= mcand_i;
         mq_q  <= mplier_i;
         acc_q <= '0;
         cy_q  <= 1'b0;
      end else if (do_add) begin
         acc_q <= sum;
         cy_q  <= cout;
      end else if (shift_i) begin
         acc_q <= {cy_q, acc_q[WIDTH-1:1]};
         mq_q  <= {acc_q[0], mq_q[WIDTH-1:1]};
         cy_q  <= 1'b0;
      end
   end

   assign prod_o = {acc_q, mq_q};

   p_skip_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (add_i && !mq_q[0]) |=> $stable(acc_q) && $stable(cy_q));
   p_mcand_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(b_q));
   p_prod_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !add_i && !shift_i) |=> $stable(prod_o));
   p_carry_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |=> !cy_q);
endmodule

// File: rtl/seq_shift_add_mult.sv
module seq_shift_add_mult #(
   parameter int WIDTH = 8,
   parameter int ADDER = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go_i,
   input  logic [WIDTH-1:0]   mcand_i,
   input  logic [WIDTH-1:0]   mplier_i,
   output logic [2*WIDTH-1:0] prod_o,
   output logic               ready_o
);
   initial begin
      assert (WIDTH >= 2) else $error("seq_shift_add_mult: WIDTH must be >= 2");
      assert (ADDER == 0 || ADDER == 1) else $error("seq_shift_add_mult: ADDER must be 0 or 1");
   end

   logic load, add, shift;

   mult_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (go_i),
      .load_o  (load),
      .add_o   (add),
      .shift_o (shift),
      .ready_o (ready_o)
   );

   mult_dpath #(.WIDTH(WIDTH), .ADDER(ADDER)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .add_i    (add),
      .shift_i  (shift),
      .mcand_i  (mcand_i),
      .mplier_i (mplier_i),
      .prod_o   (prod_o)
   );

   p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_o && go_i) |=> !($rose(ready_o) && $past(add)));
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !go_i) |=> ready_o && $stable(prod_o));
endmodule

// File: tb/tb_seq_shift_add_mult.sv
module tb_seq_shift_add_mult;
   localparam int W  = 8;
   localparam int PW = 2 * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          go_i = 1'b0;
   logic [W-1:0]  mcand_i = '0;
   logic [W-1:0]  mplier_i = '0;
   logic [PW-1:0] prod_o;
   logic          ready_o;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   seq_shift_add_mult #(.WIDTH(W), .ADDER(1)) dut (
      .clk(clk), .rst_n(rst_n), .go_i(go_i),
      .mcand_i(mcand_i), .mplier_i(mplier_i),
      .prod_o(prod_o), .ready_o(ready_o)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // start accepted at next posedge; returns at the negedge after it
   task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
      go_i = 1'b1; mcand_i = a; mplier_i = b;
      @(negedge clk);
      go_i = 1'b0;
      chk("R2", PW'(ready_o), PW'(0));
   endtask

   // waits until completion; noise: 0 none, 1 busy start pulses, 2 operand change
   task automatic finish_op(input logic [W-1:0] a, input logic [W-1:0] b, input int noise);
      logic [PW-1:0] exp;
      exp = PW'(a) * PW'(b);
      for (int i = 1; i < 2*W; i++) begin
         if (noise == 1 && (i == 3 || i == 2*W-1)) go_i = 1'b1;
         if (noise == 2) begin mcand_i = ~a; mplier_i = W'(i); end
         @(negedge clk);
         go_i = 1'b0;
      end
      chk(noise == 1 ? "R5" : "R3", PW'(ready_o), PW'(0));
      @(negedge clk);
      chk(noise == 1 ? "R5" : "R3", PW'(ready_o), PW'(1));
      chk(noise == 2 ? "R6" : (noise == 1 ? "R5" : "R3"), prod_o, exp);
   endtask

   task automatic t_reset;
      chk("R1", PW'(ready_o), PW'(1));
      chk("R1", prod_o, PW'(0));
   endtask

   task automatic t_basic(input logic [W-1:0] a, input logic [W-1:0] b);
      launch(a, b);
      finish_op(a, b, 0);
   endtask

   task automatic t_corners;
      launch(8'hA5, 8'h00); finish_op(8'hA5, 8'h00, 0);
      chk("R7", prod_o, PW'(0));
      launch(8'h00, 8'hC3); finish_op(8'h00, 8'hC3, 0);
      chk("R7", prod_o, PW'(0));
      launch(8'hFF, 8'hFF); finish_op(8'hFF, 8'hFF, 0);
      chk("R7", prod_o, 16'hFE01);
   endtask

   task automatic t_hold;
      logic [PW-1:0] keep;
      keep = prod_o;
      mcand_i = 8'h12; mplier_i = 8'h34;
      repeat (5) @(negedge clk);
      chk("R4", prod_o, keep);
      chk("R4", PW'(ready_o), PW'(1));
   endtask

   task automatic t_busy_go;
      launch(8'h9B, 8'h6D);
      finish_op(8'h9B, 8'h6D, 1);
   endtask

   task automatic t_operand_change;
      launch(8'h3C, 8'hE7);
      finish_op(8'h3C, 8'hE7, 2);
   endtask

   task automatic t_back_to_back;
      logic [PW-1:0] prev;
      launch(8'h11, 8'h0F); finish_op(8'h11, 8'h0F, 0);
      prev = prod_o;
      chk("R4", prev, 16'h00FF);
      launch(8'h80, 8'h81);
      finish_op(8'h80, 8'h81, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic(8'd7, 8'd9);
      t_basic(8'h55, 8'hAA);
      t_basic(8'h01, 8'h80);
      t_corners();
      t_hold();
      t_busy_go();
      t_operand_change();
      t_back_to_back();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule